// File: doc/BRIEF.md
# Dithered Fine-Resolution PWM Driver

This block drives a single output pin with an average duty cycle finer than its own PWM counter can resolve. A 15-bit level word is split in two parts. The upper eight bits give a whole-count duty for an 8-bit up/down (triangle) PWM counter. The lower seven bits go into a first-order error accumulator. In some periods the carry out of that accumulator adds one count to the duty, so the average duty over many periods reaches 15-bit resolution while the PWM frequency stays fixed at one period per 512 clocks.

The compare value changes only on the counter wrap. The value for the coming period is computed one period ahead and held in a staging register. The wrap edge therefore only copies a ready value into the compare register, and the arithmetic on that edge does not delay the output. A level of zero, or a low enable, stops the generator and drops the driver-enable output. When the level becomes nonzero again, the generator restarts from phase zero with the whole-count duty loaded directly, and the driver enable rises one cycle later.

Top module: `dsm_dither_pwm`

## Requirements
- R1: After reset, `pwm_out` and `drv_en` are low and stay low until a nonzero level is loaded with `enable` high.
- R2: The counter visits each value 0..255 once rising and once falling, for a 512-clock period. `pwm_out` is high while the counter is below the compare value, so a compare value C (C < 255) gives 2*C high clocks in each period.
- R3: A compare value of 255 gives a constant high output, 512 high clocks per period. The level 32640 (base 255, fraction 0) produces this.
- R4: Once running, each period has either base or base+1 as its compare value. Over 128/g consecutive dithered periods, the number of base+1 periods equals frac/g, where frac = level[6:0] and g is any power of two dividing both 128 and frac. Examples: frac 32 gives one extra count per 4 periods, and frac 64 gives one per 2 periods.
- R5: A level loaded while running first shows in the period that begins at the second counter wrap after the load edge. A wrap on the load edge itself is processed with the previous level.
- R6: Loading level 0 stops the generator. At the second clock edge after the load, `pwm_out` and `drv_en` go low and stay low.
- R7: Start-up from stopped restarts the counter at 0, so the first sampled cycle is high when base > 0. The first two periods use exactly the base duty. `drv_en` is low in the first cycle of the first period and high from the second cycle on.
- R8: A level above 32640 is clamped to 32640, so loading 32767 gives a constant high output.
- R9: `enable` low has the same effect as level 0 at the next clock edge. It wins over a counter wrap on the same edge. Raising `enable` with a nonzero stored level starts up as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_in | input | 15 | Brightness level: [14:7] base duty, [6:0] dither fraction |
| level_ld | input | 1 | Captures `level_in` (clamped) at the clock edge |
| enable | input | 1 | Run permission; low stops the generator |
| pwm_out | output | 1 | PWM output pin |
| drv_en | output | 1 | Enable for the external driver stage |

## Verification
Two events can fall on the same clock edge: the counter wrap, which moves the staged duty into the compare register and advances the accumulator, and a control event, either a new level load or a drop of `enable`. The bench applies each control event in the last cycle of a period, so it is registered exactly on the wrap edge. For a load on the wrap, the high time of the next three periods must show the old duty twice and then the new duty. For an enable drop on the wrap, both outputs must be low in the next cycle, and a later re-enable must again give base-duty periods from phase zero.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // default split of the level word
    localparam int DEF_BASE_W = 8;
    localparam int DEF_FRAC_W = 7;

    // generator run state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    // per-cycle control events decoded by the top
    typedef struct packed {
        logic start;   // stopped -> running
        logic stop;    // running -> stopped
        logic step;    // counter wrap while running
    } ctl_t;

endpackage

// File: rtl/dsm_tri_counter.sv
module dsm_tri_counter #(
    parameter int BASE_W = dsm_pkg::DEF_BASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clr,
    output logic [BASE_W-1:0] cnt,
    output logic              wrap
);
    localparam int PH_W = BASE_W + 1;
    localparam logic [PH_W-1:0] PH_LAST = '1;

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // rising half counts up, falling half mirrors it down
    always_comb begin
        if (ph_q[PH_W-1]) begin
            cnt = ~ph_q[BASE_W-1:0];
        end else begin
            cnt = ph_q[BASE_W-1:0];
        end
    end

    assign wrap = run && (ph_q == PH_LAST);

endmodule

// File: rtl/dsm_err_accum.sv
module dsm_err_accum #(
    parameter int BASE_W = dsm_pkg::DEF_BASE_W,
    parameter int FRAC_W = dsm_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  dsm_pkg::ctl_t     ctl,
    input  logic [BASE_W-1:0] base,
    input  logic [FRAC_W-1:0] frac,
    output logic [BASE_W-1:0] nxt
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, frac};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            nxt   <= '0;
        end else if (ctl.stop) begin
            nxt   <= '0;
        end else if (ctl.start) begin
            nxt   <= base;
        end else if (ctl.step) begin
            nxt   <= base + {{(BASE_W-1){1'b0}}, sum[FRAC_W]};
            acc_q <= sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/dsm_cmp_out.sv
module dsm_cmp_out #(
    parameter int BASE_W = dsm_pkg::DEF_BASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  dsm_pkg::ctl_t     ctl,
    input  logic              run,
    input  logic [BASE_W-1:0] base,
    input  logic [BASE_W-1:0] nxt,
    input  logic [BASE_W-1:0] cnt,
    output logic [BASE_W-1:0] cmp,
    output logic              pin
);
    localparam logic [BASE_W-1:0] CMP_FULL = '1;

    always_ff @(posedge clk) begin
        if (rst || ctl.stop) begin
            cmp <= '0;
        end else if (ctl.start) begin
            cmp <= base;
        end else if (ctl.step) begin
            cmp <= nxt;
        end
    end

    assign pin = run && ((cmp == CMP_FULL) || (cnt < cmp));

endmodule

// File: rtl/dsm_dither_pwm.sv
module dsm_dither_pwm #(
    parameter int BASE_W = dsm_pkg::DEF_BASE_W,
    parameter int FRAC_W = dsm_pkg::DEF_FRAC_W,
    localparam int LVL_W = BASE_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level_in,
    input  logic             level_ld,
    input  logic             enable,
    output logic             pwm_out,
    output logic             drv_en
);
    import dsm_pkg::*;

    localparam logic [LVL_W-1:0] LVL_MAX = {{BASE_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [LVL_W-1:0]  lvl_q;
    logic [LVL_W-1:0]  lvl_clamped;
    run_e              st_q;
    ctl_t              ctl;
    logic              run;
    logic              want;
    logic              wrap;
    logic [BASE_W-1:0] cnt;
    logic [BASE_W-1:0] cmp_q;
    logic [BASE_W-1:0] nxt_q;
    logic [BASE_W-1:0] base;
    logic [FRAC_W-1:0] frac;

    assign lvl_clamped = (level_in > LVL_MAX) ? LVL_MAX : level_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (level_ld) begin
            lvl_q <= lvl_clamped;
        end
    end

    assign base = lvl_q[LVL_W-1:FRAC_W];
    assign frac = lvl_q[FRAC_W-1:0];
    assign run  = (st_q == ST_RUN);
    assign want = enable && (lvl_q != '0);

    always_comb begin
        ctl.start = !run && want;
        ctl.stop  = run && !want;
        ctl.step  = run && want && wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            drv_en <= 1'b0;
        end else begin
            if (ctl.start) begin
                st_q <= ST_RUN;
            end else if (ctl.stop) begin
                st_q <= ST_IDLE;
            end
            drv_en <= run && want;
        end
    end

    dsm_tri_counter #(.BASE_W(BASE_W)) i_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .clr  (ctl.stop),
        .cnt  (cnt),
        .wrap (wrap)
    );

    dsm_err_accum #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) i_acc (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .base (base),
        .frac (frac),
        .nxt  (nxt_q)
    );

    dsm_cmp_out #(.BASE_W(BASE_W)) i_out (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .run  (run),
        .base (base),
        .nxt  (nxt_q),
        .cnt  (cnt),
        .cmp  (cmp_q),
        .pin  (pwm_out)
    );

endmodule

// File: rtl/dsm_dither_pwm_chk.sv
module dsm_dither_pwm_chk #(
    parameter int BASE_W = dsm_pkg::DEF_BASE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              pwm_out,
    input logic              drv_en,
    input logic              run,
    input logic              want,
    input logic              wrap,
    input logic [BASE_W-1:0] cmp,
    input logic [BASE_W-1:0] nxt
);
    localparam logic [BASE_W-1:0] FULL = '1;

    // R6: a stopped generator never drives the pin
    a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run |-> !pwm_out);

    // R7: the driver enable is only up while running
    a_r7_drv_needs_run: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> run);

    // R3: a full compare value keeps the pin high
    a_r3_full_high: assert property (@(posedge clk) disable iff (rst)
        (run && cmp == FULL) |-> pwm_out);

    // R5: the compare value only moves on a wrap while running
    a_r5_cmp_hold: assert property (@(posedge clk) disable iff (rst)
        (run && want && !wrap) |=> $stable(cmp));

    // R4: on a wrap the staged value becomes the compare value
    a_r4_wrap_takes_staged: assert property (@(posedge clk) disable iff (rst)
        (run && want && wrap) |=> (cmp == $past(nxt)));

    // R9: enable low shuts both outputs at the next edge
    a_r9_enable_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!drv_en && !pwm_out));

endmodule

bind dsm_dither_pwm dsm_dither_pwm_chk #(.BASE_W(BASE_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .pwm_out (pwm_out),
    .drv_en  (drv_en),
    .run     (run),
    .want    (want),
    .wrap    (wrap),
    .cmp     (cmp_q),
    .nxt     (nxt_q)
);

// File: tb/test_dsm_dither_pwm.sv
`timescale 1ns/1ps
module test_dsm_dither_pwm;

    localparam int PER = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] level_in = '0;
    logic        level_ld = 1'b0;
    logic        enable = 1'b1;
    logic        pwm_out;
    logic        drv_en;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dsm_dither_pwm i_dsm_dither_pwm (
        .clk      (clk),
        .rst      (rst),
        .level_in (level_in),
        .level_ld (level_ld),
        .enable   (enable),
        .pwm_out  (pwm_out),
        .drv_en   (drv_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_level(input logic [14:0] v);
        @(negedge clk);
        level_in = v;
        level_ld = 1'b1;
        @(negedge clk);
        level_ld = 1'b0;
    endtask

    // one 512-clock window; first=1 also checks the driver-enable timing.
    // inj: 0 none, 1 load nl in last cycle, 2 drop enable in last cycle
    task automatic period(input bit first, input int inj, input logic [14:0] nl,
                          output int hi);
        hi = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (i == 0) level_ld = 1'b0;
            if (pwm_out) hi++;
            if (first && i == 0) chk("R7 drv_en low in first cycle", int'(drv_en), 0);
            if (first && i == 1) chk("R7 drv_en high from second cycle", int'(drv_en), 1);
            if (i == PER-1 && inj == 1) begin
                level_in = nl;
                level_ld = 1'b1;
            end
            if (i == PER-1 && inj == 2) enable = 1'b0;
        end
    endtask

    task automatic stop_gen();
        load_level(15'd0);
        @(negedge clk);
        chk("R6 pwm low after zero", int'(pwm_out), 0);
        chk("R6 drv_en low after zero", int'(drv_en), 0);
    endtask

    task automatic t_reset();
        int hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_out || drv_en) hi++;
        end
        chk("R1 outputs low after reset", hi, 0);
    endtask

    task automatic t_base();
        int hi;
        load_level({8'd50, 7'd0});
        period(1'b1, 0, '0, hi);
        chk("R2 R7 period1 base 50", hi, 100);
        period(1'b0, 0, '0, hi);
        chk("R2 period2 base 50", hi, 100);
        period(1'b0, 0, '0, hi);
        chk("R2 period3 base 50", hi, 100);
    endtask

    task automatic t_load_on_wrap();
        int hi;
        period(1'b0, 1, {8'd80, 7'd0}, hi);
        chk("R2 period before load", hi, 100);
        period(1'b0, 0, '0, hi);
        chk("R5 first period after wrap load keeps old", hi, 100);
        period(1'b0, 0, '0, hi);
        chk("R5 second period after wrap load keeps old", hi, 100);
        period(1'b0, 0, '0, hi);
        chk("R5 third period uses new level", hi, 160);
    endtask

    task automatic t_zero();
        int hi = 0;
        stop_gen();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pwm_out || drv_en) hi++;
        end
        chk("R6 stays low while stopped", hi, 0);
    endtask

    task automatic t_dither();
        int hi;
        int tot = 0;
        int bad = 0;
        stop_gen();
        load_level({8'd100, 7'd32});
        period(1'b1, 0, '0, hi);
        chk("R7 startup period1 base only", hi, 200);
        period(1'b0, 0, '0, hi);
        chk("R7 startup period2 base only", hi, 200);
        for (int p = 0; p < 4; p++) begin
            period(1'b0, 0, '0, hi);
            tot += hi;
            if (hi != 200 && hi != 202) bad++;
        end
        chk("R4 each period base or base+1", bad, 0);
        chk("R4 frac 32 gives one extra per 4", tot, 802);
    endtask

    task automatic t_fine();
        int hi;
        int tot = 0;
        stop_gen();
        load_level({8'd0, 7'd64});
        period(1'b1, 0, '0, hi);
        chk("R7 base 0 startup low", hi, 0);
        period(1'b0, 0, '0, hi);
        chk("R7 base 0 second period low", hi, 0);
        for (int p = 0; p < 2; p++) begin
            period(1'b0, 0, '0, hi);
            tot += hi;
        end
        chk("R4 frac 64 gives one extra per 2", tot, 2);
    endtask

    task automatic t_full(input logic [14:0] v, input string req);
        int hi;
        stop_gen();
        load_level(v);
        for (int p = 0; p < 3; p++) begin
            period(p == 0, 0, '0, hi);
            chk(req, hi, PER);
        end
    endtask

    task automatic t_enable();
        int hi = 0;
        int hp;
        stop_gen();
        load_level({8'd50, 7'd0});
        period(1'b1, 2, '0, hp);
        chk("R9 period before enable drop", hp, 100);
        @(negedge clk);
        chk("R9 pwm low after drop on wrap", int'(pwm_out), 0);
        chk("R9 drv_en low after drop on wrap", int'(drv_en), 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out || drv_en) hi++;
        end
        chk("R9 stays off while disabled", hi, 0);
        enable = 1'b1;
        period(1'b1, 0, '0, hp);
        chk("R9 re-enable period1 base", hp, 100);
        period(1'b0, 0, '0, hp);
        chk("R9 re-enable period2 base", hp, 100);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_base();
        t_load_on_wrap();
        t_zero();
        t_dither();
        t_fine();
        t_full({8'd255, 7'd0}, "R3 level 32640 constant high");
        t_full(15'd32767, "R8 clamped level constant high");
        t_enable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule